// File: doc/BRIEF.md
# Four-Bit-Coded 32-Bit Arithmetic Logic Unit

This block is the arithmetic logic unit of a simple processor datapath. It has no state. Two 32-bit operands and a 4-bit operation code go in. A 32-bit result and a zero indication come out. The processor uses the same unit for three jobs: register-to-register arithmetic and logic, memory address generation by addition, and branch comparison by subtraction. In a branch comparison the zero indication tells whether the two operands are equal.

There are six operations. Three are bitwise: AND, OR and NOR. Two are modular: addition and subtraction. The last is a signed less-than test that returns 0 or 1. Every other operation code gives a result of zero. The subtractor also serves the less-than test, which decides from the sign of the difference corrected by the signed overflow of that difference.

Top module: `calc_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the two operands.
- R2: Operation code 4'b0001 gives the bitwise OR of the two operands.
- R3: Operation code 4'b0010 gives the sum of the operands modulo 2^32. No carry or overflow indication leaves the block.
- R4: Operation code 4'b0110 gives operand A minus operand B, modulo 2^32.
- R5: Operation code 4'b0111 gives 1 in bit 0 when A is less than B, with both operands read as signed two's complement. Otherwise bit 0 is 0. Bits 31 to 1 are always 0 for this code. The result is correct even when A minus B overflows.
- R6: Operation code 4'b1100 gives the bitwise NOR of the two operands.
- R7: The zero output is 1 exactly when all 32 result bits are 0, for every operation code.
- R8: Each of the ten operation codes not listed above gives a result of 0, so zero reads 1.
- R9: The block holds no state. Both outputs follow a change on any input without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| result | output | 32 | Operation result |
| is_zero | output | 1 | High when result is all zeros |

## Verification
The block has no register on any path, so both the result and the zero flag are due in the same cycle as the operand and code change that produces them, zero cycles later. The bench drives each new stimulus on the falling clock edge. It samples one nanosecond later, well before the next rising edge, so a check never depends on edge ordering. One scenario changes the inputs several times within a single clock phase and checks after each change, which shows that no clock edge is needed. The expected values come from a separate reference function in the bench that uses signed comparison and plain operators.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  typedef enum logic [1:0] {
    LK_AND = 2'd0,
    LK_OR  = 2'd1,
    LK_NOR = 2'd2,
    LK_NONE = 2'd3
  } logic_kind_e;

  typedef struct packed {
    logic        use_logic;
    logic        use_arith;
    logic        use_less;
    logic        subtract;
    logic_kind_e kind;
  } alu_sel_t;

  function automatic alu_sel_t decode_op(input logic [3:0] code);
    alu_sel_t s;
    s = '{use_logic: 1'b0, use_arith: 1'b0, use_less: 1'b0,
          subtract: 1'b0, kind: LK_NONE};
    case (code)
      OP_AND: begin s.use_logic = 1'b1; s.kind = LK_AND; end
      OP_OR:  begin s.use_logic = 1'b1; s.kind = LK_OR;  end
      OP_NOR: begin s.use_logic = 1'b1; s.kind = LK_NOR; end
      OP_ADD: begin s.use_arith = 1'b1; end
      OP_SUB: begin s.use_arith = 1'b1; s.subtract = 1'b1; end
      OP_SLT: begin s.use_less  = 1'b1; s.subtract = 1'b1; end
      default: ;
    endcase
    return s;
  endfunction

  // Signed less-than from a difference: sign bit corrected by overflow.
  function automatic logic signed_less(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

  // Two's complement overflow of x + y giving s.
  function automatic logic add_ovf(input logic x_msb, input logic y_msb,
                                   input logic s_msb);
    return (x_msb == y_msb) && (s_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W      = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf
);
  import alu_pkg::*;

  logic [W-1:0] b_eff;
  assign b_eff = b ^ {W{sub}};

  generate
    if (RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      assign carry[0] = sub;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = a[i] ^ b_eff[i] ^ carry[i];
        if (i < W - 1) begin : g_cy
          assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
      end
    end else begin : g_flat
      assign sum = a + b_eff + {{(W-1){1'b0}}, sub};
    end
  endgenerate

  assign ovf = add_ovf(a[W-1], b_eff[W-1], sum[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  alu_pkg::logic_kind_e kind,
  output logic [W-1:0]         y
);
  import alu_pkg::*;

  always_comb begin
    case (kind)
      LK_AND:  y = a & b;
      LK_OR:   y = a | b;
      LK_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_zero.sv
module alu_zero #(
  parameter int W     = 32,
  parameter int CHUNK = 8
) (
  input  logic [W-1:0] v,
  output logic         zero
);
  localparam int NCH = (W + CHUNK - 1) / CHUNK;

  logic [NCH*CHUNK-1:0] padded;
  logic [NCH-1:0]       any_set;

  always_comb begin
    padded = '0;
    padded[W-1:0] = v;
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chunk
      assign any_set[c] = |padded[c*CHUNK +: CHUNK];
    end
  endgenerate

  assign zero = ~|any_set;
endmodule

// File: rtl/calc_alu.sv
module calc_alu #(
  parameter int W          = 32,
  parameter bit RIPPLE_ADD = 1'b1,
  parameter int ZERO_CHUNK = 8
) (
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         is_zero
);
  import alu_pkg::*;

  alu_sel_t     sel;
  logic [W-1:0] logic_y;
  logic [W-1:0] arith_y;
  logic         sub_ovf;
  logic         less_flag;
  logic         op_known;

  assign sel      = decode_op(op_sel);
  assign op_known = sel.use_logic | sel.use_arith | sel.use_less;

  alu_logic #(.W(W)) u_logic (
    .a(opnd_a), .b(opnd_b), .kind(sel.kind), .y(logic_y)
  );

  alu_addsub #(.W(W), .RIPPLE(RIPPLE_ADD)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(sel.subtract), .sum(arith_y), .ovf(sub_ovf)
  );

  assign less_flag = signed_less(arith_y[W-1], sub_ovf);

  always_comb begin
    result = '0;
    if (sel.use_logic)      result = logic_y;
    else if (sel.use_arith) result = arith_y;
    else if (sel.use_less)  result = {{(W-1){1'b0}}, less_flag};
  end

  alu_zero #(.W(W), .CHUNK(ZERO_CHUNK)) u_zero (
    .v(result), .zero(is_zero)
  );
endmodule

// File: rtl/calc_alu_chk.sv
module calc_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]   op_sel,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [W-1:0] result,
  input logic         is_zero,
  input logic         sub_ovf,
  input logic         less_flag,
  input logic         op_known
);
  import alu_pkg::*;

  always_comb begin
    if (op_sel == OP_AND) p_and_r1: assert (result == (opnd_a & opnd_b));
    if (op_sel == OP_OR)  p_or_r2:  assert (result == (opnd_a | opnd_b));
    if (op_sel == OP_ADD) p_add_r3: assert (result == opnd_a + opnd_b);
    if (op_sel == OP_SUB) p_sub_r4: assert (result == opnd_a - opnd_b);
    if (op_sel == OP_SLT) begin
      p_slt_upper_r5: assert (result[W-1:1] == '0);
      p_slt_value_r5: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)));
      p_slt_flag_r5:  assert (less_flag == result[0]);
    end
    if (op_sel == OP_NOR) p_nor_r6: assert (result == ~(opnd_a | opnd_b));
    p_zero_flag_r7: assert (is_zero == (result == '0));
    if (!op_known) p_unlisted_r8: assert (result == '0 && is_zero);
    if (op_sel == OP_SUB && sub_ovf)
      p_sub_ovf_r4: assert (opnd_a[W-1] != opnd_b[W-1]);
  end
endmodule

bind calc_alu calc_alu_chk #(.W(W)) u_chk (
  .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
  .is_zero(is_zero), .sub_ovf(sub_ovf), .less_flag(less_flag),
  .op_known(op_known)
);

// File: tb/calc_alu_bench.sv
module calc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = 4'b0000;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;
  logic        is_zero;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  calc_alu u_calc_alu (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .is_zero(is_zero)
  );

  function automatic logic [31:0] ref_res(input logic [3:0] c,
                                          input logic [31:0] x,
                                          input logic [31:0] y);
    case (c)
      4'h0: return x & y;
      4'h1: return x | y;
      4'h2: return x + y;
      4'h6: return x + (~y) + 32'd1;
      4'h7: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'hC: return ~x & ~y;
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare(input string tag, input logic [3:0] c,
                         input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er;
    logic ez;
    er = ref_res(c, x, y);
    ez = (er == 32'd0);
    total++;
    if (result !== er || is_zero !== ez) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h: got result=%h zero=%b, want result=%h zero=%b",
               tag, c, x, y, result, is_zero, er, ez);
    end
  endtask

  task automatic apply(input string tag, input logic [3:0] c,
                       input logic [31:0] x, input logic [31:0] y);
    @(negedge clk);
    op_sel = c; opnd_a = x; opnd_b = y;
    #1;
    compare(tag, c, x, y);
  endtask

  task automatic t_reset_state;
    #1;
    compare("R7 reset state", 4'h0, 32'd0, 32'd0);
  endtask

  task automatic t_logic;
    apply("R1 and", 4'h0, 32'hF0F0_A5A5, 32'hFF00_0FF0);
    apply("R1 and disjoint", 4'h0, 32'hAAAA_AAAA, 32'h5555_5555);
    apply("R2 or", 4'h1, 32'h1234_0000, 32'h0000_5678);
    apply("R2 or zeros", 4'h1, 32'd0, 32'd0);
    apply("R6 nor", 4'hC, 32'h0F0F_0000, 32'h0000_F0F0);
    apply("R6 nor all ones", 4'hC, 32'hFFFF_0000, 32'h0000_FFFF);
  endtask

  task automatic t_arith;
    apply("R3 add", 4'h2, 32'd100, 32'd23);
    apply("R3 add wrap", 4'h2, 32'hFFFF_FFFF, 32'd1);
    apply("R3 add signed ovf", 4'h2, 32'h7FFF_FFFF, 32'd1);
    apply("R4 sub", 4'h6, 32'd50, 32'd8);
    apply("R4 sub equal", 4'h6, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply("R4 sub borrow", 4'h6, 32'd0, 32'd1);
  endtask

  task automatic t_less;
    apply("R5 min<max", 4'h7, 32'h8000_0000, 32'h7FFF_FFFF);
    apply("R5 max<min", 4'h7, 32'h7FFF_FFFF, 32'h8000_0000);
    apply("R5 equal", 4'h7, 32'd9, 32'd9);
    apply("R5 neg<0", 4'h7, 32'hFFFF_FFFF, 32'd0);
    apply("R5 small", 4'h7, 32'd3, 32'd4);
  endtask

  task automatic t_unlisted;
    for (int c = 0; c < 16; c++) begin
      apply("R8 code sweep", c[3:0], 32'hFFFF_FFFF, 32'h1357_9BDF);
    end
  endtask

  task automatic t_no_clock;
    @(posedge clk);
    #1;
    op_sel = 4'h2; opnd_a = 32'd7; opnd_b = 32'd5; #1;
    compare("R9 settle no edge", 4'h2, 32'd7, 32'd5);
    opnd_b = 32'hFFFF_FFF9; #1;
    compare("R9 operand change", 4'h2, 32'd7, 32'hFFFF_FFF9);
    op_sel = 4'h6; #1;
    compare("R9 code change", 4'h6, 32'd7, 32'hFFFF_FFF9);
  endtask

  task automatic t_sweep;
    logic [31:0] lf;
    logic [3:0] codes [6];
    codes = '{4'h0, 4'h1, 4'h2, 4'h6, 4'h7, 4'hC};
    lf = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] x;
      x = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      apply("R7 mixed sweep", codes[i % 6], x, lf);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic();
    t_arith();
    t_less();
    t_unlisted();
    t_no_clock();
    t_sweep();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule